// File: doc/BRIEF.md
# Event Counter Setup and Command Front End

This block sits between a register-style write port and the core of a programmable event counter. Software first defines the counter once: it gives a counting mode from 0 to 12 and three setup bits that choose the polarity of the reset input, the polarity of the start input and the quadrature counting rate. After that, software issues command strobes. Each strobe carries an 8-bit control byte, a signed 32-bit current value and a signed 32-bit preset value. The block decodes the control byte into enable, direction, preset-load and current-value-load actions for the core.

Every define or command strobe produces a registered error code. The code stays on the output until the next strobe, and 0 means success. The definition can be made only once per run session. A run/stop input ends the session, which clears the definition so the counter can be defined again. The block does not count, route pins or raise interrupts.

Top module: `evctr_cfg_unit`

## Requirements
- R1: While undefined and running, a define strobe with a mode of 0 to 12 latches the mode and the setup bits and reports error 0. The setup bits are: bit 0 is the reset polarity (1 = active low), bit 1 is the start polarity (1 = active low), and bit 2 is the quadrature rate (0 = 4x, 1 = 1x).
- R2: A define strobe while already defined leaves mode and setup unchanged and reports error 0x000A.
- R3: A define strobe with a mode above 12 leaves the block undefined and unchanged and reports error 0x0002.
- R4: A command strobe before any definition reports error 0x0001 and changes no counter-facing output.
- R5: Control bit 4 set copies control bit 3 to the direction output (1 = up), with a one-cycle direction-load pulse; otherwise the direction is unchanged.
- R6: Control bit 5 set loads the new preset value, with a one-cycle preset-load pulse; otherwise the preset is unchanged.
- R7: Control bit 6 set loads the new current value, with a one-cycle current-load pulse. The enable output is low in that cycle and takes control bit 7 in the cycle after.
- R8: Without bit 6, enable takes control bit 7 in the cycle after the strobe, so a control byte of 0x00 disables the counter and changes nothing else.
- R9: Direction, preset and current-value updates combine freely in one command strobe.
- R10: The error output is registered, changes only on a define or command strobe while running, and a strobe that succeeds reports 0.
- R11: When run is low, the definition and the enable are cleared and strobes are ignored. After run returns high, a new definition is accepted.
- R12: When define and command strobe in the same cycle, only the define is handled and the command is discarded.
- R13: After reset: undefined, mode 0, setup bits 0 (active high, 4x), disabled, direction up, preset and current value 0, no pulses, error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | 1 = run session, 0 = stop |
| def_stb_i | input | 1 | Define strobe |
| def_mode_i | input | 4 | Counting mode 0..12 |
| def_setup_i | input | 3 | Setup bits: reset polarity, start polarity, quadrature rate |
| cmd_stb_i | input | 1 | Command strobe |
| cmd_ctrl_i | input | 8 | Control byte |
| cmd_cur_i | input | 32 | New current value (signed) |
| cmd_pre_i | input | 32 | New preset value (signed) |
| defined_o | output | 1 | Definition held |
| mode_o | output | 4 | Latched mode |
| rst_low_o | output | 1 | Reset input is active low |
| start_low_o | output | 1 | Start input is active low |
| quad_1x_o | output | 1 | Quadrature rate 1x (0 = 4x) |
| enable_o | output | 1 | Counter enable |
| dir_up_o | output | 1 | Counting direction, 1 = up |
| preset_o | output | 32 | Preset value (signed) |
| cur_val_o | output | 32 | Current value to load (signed) |
| ld_dir_o | output | 1 | Direction-load pulse |
| ld_pre_o | output | 1 | Preset-load pulse |
| ld_cur_o | output | 1 | Current-value-load pulse |
| err_o | output | 16 | Error code of last strobe, 0 = none |

## Verification
The assertions check on every cycle the cases that involve only a cycle or two. A redefinition leaves the mode frozen and returns 0x000A. A premature command returns 0x0001 with no load pulse. The enable is low during a current-value load. Load pulses never occur without a command strobe in the cycle before. Stop clears the definition and the enable.

Only the bench's scenarios show the longer sequences. These include the enable taking bit 7 one cycle after a load, error codes held across idle cycles, combined updates applied together, a command discarded when it strobes with a define, and a fresh definition accepted after a stop/run cycle. The bench shows these by comparing against its reference model.

// File: rtl/evctr_cfg_pkg.sv
// Shared constants for the event counter setup and command front end.
package evctr_cfg_pkg;
    localparam int MODE_W   = 4;
    localparam int MODE_MAX = 12;
    localparam int SETUP_W  = 3;
    localparam int CTRL_W   = 8;
    localparam int VAL_W    = 32;
    localparam int ERR_W    = 16;

    // control byte bit positions
    localparam int CB_DIR    = 3;
    localparam int CB_UPD_DIR = 4;
    localparam int CB_UPD_PRE = 5;
    localparam int CB_UPD_CUR = 6;
    localparam int CB_EN     = 7;

    // setup bit positions
    localparam int SU_RST_LOW   = 0;
    localparam int SU_START_LOW = 1;
    localparam int SU_QUAD_1X   = 2;

    localparam logic [ERR_W-1:0] ERR_NONE    = 16'h0000;
    localparam logic [ERR_W-1:0] ERR_NODEF   = 16'h0001;
    localparam logic [ERR_W-1:0] ERR_BADMODE = 16'h0002;
    localparam logic [ERR_W-1:0] ERR_REDEF   = 16'h000A;
endpackage

// File: rtl/evctr_cfg_latch.sv
// Holds the one-time definition (mode and setup bits).
// Assumes: run_i low ends the session; a define is judged against the state before the edge.
module evctr_cfg_latch
    import evctr_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               def_stb_i,
    input  logic [MODE_W-1:0]  def_mode_i,
    input  logic [SETUP_W-1:0] def_setup_i,
    output logic               defined_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [SETUP_W-1:0] setup_o,
    output logic [ERR_W-1:0]   def_err_o
);
    logic mode_ok;

    // Judge the define request against the present state.
    always_comb begin
        mode_ok = (int'(def_mode_i) <= MODE_MAX);
        if (defined_o)     def_err_o = ERR_REDEF;
        else if (!mode_ok) def_err_o = ERR_BADMODE;
        else               def_err_o = ERR_NONE;
    end

    // Latch the definition once per session; a stop clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            defined_o <= 1'b0;
            mode_o    <= '0;
            setup_o   <= '0;
        end else if (!run_i) begin
            defined_o <= 1'b0;
        end else if (def_stb_i && def_err_o == ERR_NONE) begin
            defined_o <= 1'b1;
            mode_o    <= def_mode_i;
            setup_o   <= def_setup_i;
        end
    end
endmodule

// File: rtl/evctr_cmd_decode.sv
// Turns an accepted command's control byte into enable, direction and load actions.
// Assumes: cmd_go_i is already qualified by run, definition and define priority.
module evctr_cmd_decode
    import evctr_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              cmd_go_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [VAL_W-1:0]  cur_i,
    input  logic [VAL_W-1:0]  pre_i,
    output logic              enable_o,
    output logic              dir_up_o,
    output logic [VAL_W-1:0]  preset_o,
    output logic [VAL_W-1:0]  cur_val_o,
    output logic              ld_dir_o,
    output logic              ld_pre_o,
    output logic              ld_cur_o
);
    logic en_pend_q;   // enable value to apply after a current-value load
    logic pend_q;      // a post-load enable is waiting

    // Register the counter-facing state and the one-cycle load pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o  <= 1'b0;
            dir_up_o  <= 1'b1;
            preset_o  <= '0;
            cur_val_o <= '0;
            ld_dir_o  <= 1'b0;
            ld_pre_o  <= 1'b0;
            ld_cur_o  <= 1'b0;
            en_pend_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            ld_dir_o <= 1'b0;
            ld_pre_o <= 1'b0;
            ld_cur_o <= 1'b0;
            if (pend_q) begin
                enable_o <= en_pend_q;
                pend_q   <= 1'b0;
            end
            if (!run_i) begin
                enable_o <= 1'b0;
                pend_q   <= 1'b0;
            end else if (cmd_go_i) begin
                if (ctrl_i[CB_UPD_DIR]) begin
                    dir_up_o <= ctrl_i[CB_DIR];
                    ld_dir_o <= 1'b1;
                end
                if (ctrl_i[CB_UPD_PRE]) begin
                    preset_o <= pre_i;
                    ld_pre_o <= 1'b1;
                end
                if (ctrl_i[CB_UPD_CUR]) begin
                    cur_val_o <= cur_i;
                    ld_cur_o  <= 1'b1;
                    enable_o  <= 1'b0;
                    en_pend_q <= ctrl_i[CB_EN];
                    pend_q    <= 1'b1;
                end else begin
                    enable_o <= ctrl_i[CB_EN];
                    pend_q   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/evctr_cfg_unit.sv
// Top of the event counter setup and command front end.
// Assumes: one strobe handled per cycle, define wins over command.
module evctr_cfg_unit
    import evctr_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_i,
    input  logic        def_stb_i,
    input  logic [3:0]  def_mode_i,
    input  logic [2:0]  def_setup_i,
    input  logic        cmd_stb_i,
    input  logic [7:0]  cmd_ctrl_i,
    input  logic [31:0] cmd_cur_i,
    input  logic [31:0] cmd_pre_i,
    output logic        defined_o,
    output logic [3:0]  mode_o,
    output logic        rst_low_o,
    output logic        start_low_o,
    output logic        quad_1x_o,
    output logic        enable_o,
    output logic        dir_up_o,
    output logic [31:0] preset_o,
    output logic [31:0] cur_val_o,
    output logic        ld_dir_o,
    output logic        ld_pre_o,
    output logic        ld_cur_o,
    output logic [15:0] err_o
);
    logic [SETUP_W-1:0] setup;
    logic [ERR_W-1:0]   def_err;
    logic               cmd_go;

    evctr_cfg_latch u_latch (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .def_stb_i(def_stb_i), .def_mode_i(def_mode_i), .def_setup_i(def_setup_i),
        .defined_o(defined_o), .mode_o(mode_o), .setup_o(setup), .def_err_o(def_err)
    );

    // A command proceeds only while running, defined and not shadowed by a define.
    always_comb cmd_go = run_i && cmd_stb_i && !def_stb_i && defined_o;

    evctr_cmd_decode u_cmd (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmd_go_i(cmd_go),
        .ctrl_i(cmd_ctrl_i), .cur_i(cmd_cur_i), .pre_i(cmd_pre_i),
        .enable_o(enable_o), .dir_up_o(dir_up_o), .preset_o(preset_o),
        .cur_val_o(cur_val_o), .ld_dir_o(ld_dir_o), .ld_pre_o(ld_pre_o),
        .ld_cur_o(ld_cur_o)
    );

    // Break the setup bits out to named outputs.
    always_comb begin
        rst_low_o   = setup[SU_RST_LOW];
        start_low_o = setup[SU_START_LOW];
        quad_1x_o   = setup[SU_QUAD_1X];
    end

    // Record the result of the latest strobe and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= ERR_NONE;
        else if (run_i && def_stb_i)
            err_o <= def_err;
        else if (run_i && cmd_stb_i)
            err_o <= defined_o ? ERR_NONE : ERR_NODEF;
    end
endmodule

// File: rtl/evctr_cfg_chk.sv
// Checker bound to evctr_cfg_unit; watches the ports only.
module evctr_cfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_i,
    input logic        def_stb_i,
    input logic [3:0]  def_mode_i,
    input logic        cmd_stb_i,
    input logic [7:0]  cmd_ctrl_i,
    input logic        defined_o,
    input logic [3:0]  mode_o,
    input logic        enable_o,
    input logic        ld_dir_o,
    input logic        ld_pre_o,
    input logic        ld_cur_o,
    input logic [15:0] err_o
);
    assert_redef_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && def_stb_i && defined_o) |=> (err_o == 16'h000A && mode_o == $past(mode_o)));

    assert_bad_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && def_stb_i && !defined_o && def_mode_i > 4'd12) |=> (err_o == 16'h0002 && !defined_o));

    assert_cmd_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cmd_stb_i && !def_stb_i && !defined_o)
        |=> (err_o == 16'h0001 && !ld_dir_o && !ld_pre_o && !ld_cur_o));

    assert_load_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cur_o |-> !enable_o);

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_dir_o || ld_pre_o || ld_cur_o) |-> $past(cmd_stb_i && !def_stb_i && run_i));

    assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!defined_o && !enable_o));

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!def_stb_i && !cmd_stb_i) |=> $stable(err_o));
endmodule

bind evctr_cfg_unit evctr_cfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .def_stb_i(def_stb_i),
    .def_mode_i(def_mode_i), .cmd_stb_i(cmd_stb_i), .cmd_ctrl_i(cmd_ctrl_i),
    .defined_o(defined_o), .mode_o(mode_o), .enable_o(enable_o),
    .ld_dir_o(ld_dir_o), .ld_pre_o(ld_pre_o), .ld_cur_o(ld_cur_o), .err_o(err_o)
);

// File: tb/evctr_cfg_unit_tb.sv
module evctr_cfg_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b1;
    logic def_stb_i = 1'b0;
    logic [3:0] def_mode_i = '0;
    logic [2:0] def_setup_i = '0;
    logic cmd_stb_i = 1'b0;
    logic [7:0] cmd_ctrl_i = '0;
    logic [31:0] cmd_cur_i = '0;
    logic [31:0] cmd_pre_i = '0;
    logic defined_o, rst_low_o, start_low_o, quad_1x_o, enable_o, dir_up_o;
    logic ld_dir_o, ld_pre_o, ld_cur_o;
    logic [3:0] mode_o;
    logic [31:0] preset_o, cur_val_o;
    logic [15:0] err_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    evctr_cfg_unit u_dut (.*);

    // behavioural reference
    bit m_def, m_en, m_dir, m_ldd, m_ldp, m_ldc, m_wait, m_wait_en;
    int m_mode, m_setup, m_err;
    int m_pre, m_cur;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_def = 0; m_mode = 0; m_setup = 0; m_en = 0; m_dir = 1;
            m_pre = 0; m_cur = 0; m_ldd = 0; m_ldp = 0; m_ldc = 0;
            m_err = 0; m_wait = 0; m_wait_en = 0;
        end else begin
            m_ldd = 0; m_ldp = 0; m_ldc = 0;
            if (m_wait) begin m_en = m_wait_en; m_wait = 0; end
            if (!run_i) begin
                m_def = 0; m_en = 0; m_wait = 0;
            end else if (def_stb_i) begin
                if (m_def) m_err = 'hA;
                else if (def_mode_i > 12) m_err = 2;
                else begin m_def = 1; m_mode = def_mode_i; m_setup = def_setup_i; m_err = 0; end
            end else if (cmd_stb_i) begin
                if (!m_def) m_err = 1;
                else begin
                    m_err = 0;
                    if (cmd_ctrl_i[4]) begin m_dir = cmd_ctrl_i[3]; m_ldd = 1; end
                    if (cmd_ctrl_i[5]) begin m_pre = cmd_pre_i; m_ldp = 1; end
                    if (cmd_ctrl_i[6]) begin
                        m_cur = cmd_cur_i; m_ldc = 1; m_en = 0;
                        m_wait = 1; m_wait_en = cmd_ctrl_i[7];
                    end else begin
                        m_en = cmd_ctrl_i[7]; m_wait = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) if (rst_n) begin
        chk("R1", "defined", defined_o, m_def);
        chk("R1", "mode", mode_o, m_mode);
        chk("R1", "setup", {quad_1x_o, start_low_o, rst_low_o}, m_setup);
        chk("R8", "enable", enable_o, m_en);
        chk("R5", "dir", dir_up_o, m_dir);
        chk("R6", "preset", preset_o, longint'(unsigned'(m_pre)));
        chk("R7", "cur", cur_val_o, longint'(unsigned'(m_cur)));
        chk("R9", "pulses", {ld_dir_o, ld_pre_o, ld_cur_o}, {m_ldd, m_ldp, m_ldc});
        chk("R10", "err", err_o, m_err);
    end

    task automatic define(input int mode, input int setup);
        @(negedge clk); def_stb_i = 1; def_mode_i = 4'(mode); def_setup_i = 3'(setup);
        @(negedge clk); def_stb_i = 0;
    endtask

    task automatic command(input int ctrl, input int cur, input int pre);
        @(negedge clk); cmd_stb_i = 1; cmd_ctrl_i = 8'(ctrl); cmd_cur_i = cur; cmd_pre_i = pre;
        @(negedge clk); cmd_stb_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                // R13 reset state
                chk("R13", "defined", defined_o, 0);
                chk("R13", "dir", dir_up_o, 1);
                chk("R13", "err", err_o, 0);
                chk("R13", "enable", enable_o, 0);
                command('hF8, 5, 9);
                chk("R4", "err", err_o, 1);
                chk("R4", "preset", preset_o, 0);
                define(13, 0);
                chk("R3", "err", err_o, 2);
                chk("R3", "defined", defined_o, 0);
                define(11, 5);
                chk("R1", "mode", mode_o, 11);
                chk("R1", "quad", quad_1x_o, 1);
                define(3, 2);
                chk("R2", "err", err_o, 'hA);
                chk("R2", "mode", mode_o, 11);
                command('hF8, 100, -7);
                chk("R7", "enable low on load", enable_o, 0);
                chk("R9", "cur", cur_val_o, 100);
                @(negedge clk);
                chk("R7", "enable after load", enable_o, 1);
                idle(3);
                chk("R10", "err held", err_o, 0);
                command('hA0, 0, 42);
                chk("R6", "preset", preset_o, 42);
                command('h90, 0, 0);
                chk("R5", "dir down", dir_up_o, 0);
                command('h00, 1, 1);
                chk("R8", "disabled", enable_o, 0);
                chk("R8", "preset kept", preset_o, 42);
                command('h40, -3, 0);
                idle(2);
                chk("R7", "stay disabled", enable_o, 0);
                command('h80, 0, 0);
                // simultaneous strobes
                @(negedge clk); def_stb_i = 1; cmd_stb_i = 1; cmd_ctrl_i = 'h20; cmd_pre_i = 77;
                @(negedge clk); def_stb_i = 0; cmd_stb_i = 0;
                chk("R12", "preset untouched", preset_o, 42);
                chk("R12", "err", err_o, 'hA);
                @(negedge clk); run_i = 0;
                define(4, 0);
                chk("R11", "defined", defined_o, 0);
                chk("R11", "enable", enable_o, 0);
                @(negedge clk); run_i = 1;
                define(4, 3);
                chk("R11", "redefine mode", mode_o, 4);
                command('hF8, 7, 8);
                idle(4);
            end
            begin
                repeat (20000) @(posedge clk);
                n_err++; n_chk++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule